// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Cell

This block models one programmable logic cell. Two 4-input lookup tables each realise any Boolean function of their own four inputs, and a third, 3-input table merges those two results with one extra internal signal. Four shared control lines are steered by configuration to that extra signal, to a direct data input, to a set/reset line and to a clock enable. Two flip-flops each store a value picked by a configuration multiplexer, and two combinational outputs show either the merged result or the matching 4-input result.

The configuration is a 58-bit word shifted in one bit per clock while the load strobe is high. It then stays fixed while the cell runs. All steering inside the cell comes from configuration bits. No user signal selects a path.

Top module: `lcell_top`

## Requirements
- R1: While `rst_n` is low, the configuration word and both flip-flops are cleared, so `x`, `y`, `xq` and `yq` all read 0.
- R2: While `cfgEn` is high, each rising clock edge shifts `cfgIn` into the top of the configuration word and moves every bit one place down. The bit sent first therefore lands in bit 0 after 58 shifts. Layout: [15:0] first table, [31:16] second table, [39:32] merge table, [41:40] extra-signal source, [43:42] data-in source, [45:44] set/reset source, [47:46] enable source, [48] enable used, [49] set/reset used, [51:50] X-flop data select, [53:52] Y-flop data select, [54] X set/reset sets, [55] Y set/reset sets, [56] X shows merge, [57] Y shows merge.
- R3: The first result is table bit {F4,F3,F2,F1}, where `lutF[0]` is F1. The second result is table bit {G4..G1}. When its show-merge bit is 0, `x` gives the first result and `y` gives the second.
- R4: The merge result is merge-table bit {extra, second, first}, with the first result as the LSB. When its show-merge bit is 1, `x` or `y` gives the merge result.
- R5: A source code n (0 to 3) routes `ctl[n]` to the extra signal, to data-in, to set/reset or to enable.
- R6: Data select 0/1/2/3 picks first/second/merge/data-in. An enabled flop loads the selected value on the rising edge. When the enable-used bit is 0, the enable is always on.
- R7: With the enable used and its control line low, both flops hold across clock edges.
- R8: With set/reset used and its line high, each flop goes at once, without a clock, to 1 if its sets bit is set and to 0 otherwise, and it stays there over clock edges. With set/reset not used, the line has no effect.
- R9: While `cfgEn` is high, both flops hold and set/reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgEn | input | 1 | Configuration shift enable |
| cfgIn | input | 1 | Serial configuration bit |
| lutF | input | 4 | First table inputs, bit 0 is F1 |
| lutG | input | 4 | Second table inputs, bit 0 is G1 |
| ctl | input | 4 | Shared control lines, bit 0 is C1 |
| x | output | 1 | Combinational output X |
| y | output | 1 | Combinational output Y |
| xq | output | 1 | Registered output of the X flop |
| yq | output | 1 | Registered output of the Y flop |

## Verification
The bench builds the cell with the package defaults: 4-input tables and four control lines. At that size the full input space of both tables, 256 joint patterns, can be swept against a truth-table model for each random table load. Because the merge table has only eight entries, random patterns reach every merge index many times. Asynchronous set and clear are checked between clock edges, where a late or clocked response would be visible.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LUT_K   = 4;
  localparam int LUT_W   = 1 << LUT_K;
  localparam int MRG_K   = 3;
  localparam int MRG_W   = 1 << MRG_K;
  localparam int CTL_N   = 4;
  localparam int CTL_SW  = $clog2(CTL_N);
  localparam int DSRC_N  = 4;
  localparam int DSRC_SW = $clog2(DSRC_N);

  typedef struct packed {
    logic               yOutH;
    logic               xOutH;
    logic               ySrSet;
    logic               xSrSet;
    logic [DSRC_SW-1:0] yDSel;
    logic [DSRC_SW-1:0] xDSel;
    logic               srUse;
    logic               ecUse;
    logic [CTL_SW-1:0]  selEc;
    logic [CTL_SW-1:0]  selSr;
    logic [CTL_SW-1:0]  selDin;
    logic [CTL_SW-1:0]  selH1;
    logic [MRG_W-1:0]   hLut;
    logic [LUT_W-1:0]   gLut;
    logic [LUT_W-1:0]   fLut;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic h1;
    logic din;
    logic ffEn;
    logic xSet;
    logic xClr;
    logic ySet;
    logic yClr;
  } strb_t;
endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgEn,
  input  logic             cfgIn,
  input  logic [CTL_N-1:0] ctl,
  output cfg_t             cfg,
  output strb_t            strb
);
  logic [CFG_W-1:0] cfgReg;
  logic             srLine;

  // R2: serial load, newest bit enters at the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfgReg <= '0;
    else if (cfgEn) cfgReg <= {cfgIn, cfgReg[CFG_W-1:1]};
  end

  assign cfg = cfg_t'(cfgReg);

  // R5 / R8 / R9: control routing with load-time gating
  assign srLine = cfg.srUse & ctl[cfg.selSr] & ~cfgEn;

  always_comb begin
    strb.h1   = ctl[cfg.selH1];
    strb.din  = ctl[cfg.selDin];
    strb.ffEn = (~cfg.ecUse | ctl[cfg.selEc]) & ~cfgEn;
    strb.xSet = srLine &  cfg.xSrSet;
    strb.xClr = srLine & ~cfg.xSrSet;
    strb.ySet = srLine &  cfg.ySrSet;
    strb.yClr = srLine & ~cfg.ySrSet;
  end
endmodule

// File: rtl/lcell_dp.sv
module lcell_dp
  import lcell_pkg::*;
(
  input  cfg_t             cfg,
  input  strb_t            strb,
  input  logic [LUT_K-1:0] lutF,
  input  logic [LUT_K-1:0] lutG,
  output logic             x,
  output logic             y,
  output logic             dX,
  output logic             dY
);
  logic              fRes;
  logic              gRes;
  logic              hRes;
  logic [DSRC_N-1:0] dSrc;

  assign fRes = cfg.fLut[lutF];
  assign gRes = cfg.gLut[lutG];
  assign hRes = cfg.hLut[{strb.h1, gRes, fRes}];

  assign x = cfg.xOutH ? hRes : fRes;
  assign y = cfg.yOutH ? hRes : gRes;

  assign dSrc = {strb.din, hRes, gRes, fRes};
  assign dX   = dSrc[cfg.xDSel];
  assign dY   = dSrc[cfg.yDSel];
endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic setQ,
  input  logic clrQ,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n or posedge setQ or posedge clrQ) begin
    if (!rst_n)    q <= 1'b0;
    else if (clrQ) q <= 1'b0;
    else if (setQ) q <= 1'b1;
    else if (en)   q <= d;
  end
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgEn,
  input  logic             cfgIn,
  input  logic [LUT_K-1:0] lutF,
  input  logic [LUT_K-1:0] lutG,
  input  logic [CTL_N-1:0] ctl,
  output logic             x,
  output logic             y,
  output logic             xq,
  output logic             yq
);
  cfg_t       cfg;
  strb_t      strb;
  logic       dX;
  logic       dY;
  logic [1:0] dVec;
  logic [1:0] setVec;
  logic [1:0] clrVec;
  logic [1:0] qVec;

  lcell_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgEn(cfgEn), .cfgIn(cfgIn),
    .ctl(ctl), .cfg(cfg), .strb(strb)
  );

  lcell_dp u_dp (
    .cfg(cfg), .strb(strb), .lutF(lutF), .lutG(lutG),
    .x(x), .y(y), .dX(dX), .dY(dY)
  );

  assign dVec   = {dY, dX};
  assign setVec = {strb.ySet, strb.xSet};
  assign clrVec = {strb.yClr, strb.xClr};

  for (genvar i = 0; i < 2; i++) begin : g_ff
    lcell_ff u_ff (
      .clk(clk), .rst_n(rst_n), .setQ(setVec[i]), .clrQ(clrVec[i]),
      .en(strb.ffEn), .d(dVec[i]), .q(qVec[i])
    );
  end

  assign xq = qVec[0];
  assign yq = qVec[1];
endmodule

// File: rtl/lcell_chk.sv
module lcell_chk
  import lcell_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  cfgEn,
  input strb_t strb,
  input logic  dX,
  input logic  dY,
  input logic  xq,
  input logic  yq
);
  AST_CFG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cfgEn && $past(cfgEn) |-> $stable({xq, yq}));                       // R9
  AST_SET_X: assert property (@(posedge clk) disable iff (!rst_n)
    strb.xSet |-> xq);                                                  // R8
  AST_CLR_X: assert property (@(posedge clk) disable iff (!rst_n)
    strb.xClr |-> !xq);                                                 // R8
  AST_SET_Y: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ySet |-> yq);                                                  // R8
  AST_CLR_Y: assert property (@(posedge clk) disable iff (!rst_n)
    strb.yClr |-> !yq);                                                 // R8
  AST_EN_HOLD_X: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!strb.ffEn && !strb.xSet && !strb.xClr) && !strb.xSet && !strb.xClr
    |-> $stable(xq));                                                   // R7
  AST_CAPTURE_X: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(strb.ffEn && !strb.xSet && !strb.xClr) && !strb.xSet && !strb.xClr
    |-> xq == $past(dX));                                               // R6
  AST_CAPTURE_Y: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(strb.ffEn && !strb.ySet && !strb.yClr) && !strb.ySet && !strb.yClr
    |-> yq == $past(dY));                                               // R6
endmodule

bind lcell_top lcell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfgEn(cfgEn), .strb(strb),
  .dX(dX), .dY(dY), .xq(xq), .yq(yq)
);

// File: tb/lcell_top_tb.sv
`timescale 1ns/1ps
module lcell_top_tb;
  import lcell_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgEn = 1'b0;
  logic       cfgIn = 1'b0;
  logic [3:0] lutF = '0;
  logic [3:0] lutG = '0;
  logic [3:0] ctl = '0;
  logic       x, y, xq, yq;
  int         errCnt = 0;
  int         chkCnt = 0;
  cfg_t       cur;

  always #2.5 clk = ~clk;

  lcell_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfgEn(cfgEn), .cfgIn(cfgIn),
    .lutF(lutF), .lutG(lutG), .ctl(ctl),
    .x(x), .y(y), .xq(xq), .yq(yq)
  );

  task automatic check(string req, logic act, logic exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic mF(cfg_t c, logic [3:0] f);
    return c.fLut[f];
  endfunction
  function automatic logic mG(cfg_t c, logic [3:0] g);
    return c.gLut[g];
  endfunction
  function automatic logic mH(cfg_t c, logic [3:0] f, logic [3:0] g, logic [3:0] k);
    return c.hLut[{k[c.selH1], c.gLut[g], c.fLut[f]}];
  endfunction
  function automatic logic mD(cfg_t c, logic [1:0] s, logic [3:0] f, logic [3:0] g, logic [3:0] k);
    case (s)
      2'd0:    return mF(c, f);
      2'd1:    return mG(c, g);
      2'd2:    return mH(c, f, g, k);
      default: return k[c.selDin];
    endcase
  endfunction

  // shift a word in, bit 0 first; cfgEn stays high on return
  task automatic shiftCfg(cfg_t c);
    @(negedge clk);
    cfgEn = 1'b1;
    for (int i = 0; i < CFG_W; i++) begin
      cfgIn = c[i];
      @(negedge clk);
    end
    cur = c;
  endtask

  task automatic loadCfg(cfg_t c);
    shiftCfg(c);
    cfgEn = 1'b0;
    #1;
  endtask

  task automatic randTables(inout cfg_t c);
    c.fLut = 16'($urandom);
    c.gLut = 16'($urandom);
    c.hLut = 8'($urandom);
  endtask

  task automatic testReset();
    check("R1 x", x, 1'b0);
    check("R1 y", y, 1'b0);
    check("R1 xq", xq, 1'b0);
    check("R1 yq", yq, 1'b0);
  endtask

  task automatic testLut4();
    for (int r = 0; r < 3; r++) begin
      cfg_t c = '0;
      randTables(c);
      loadCfg(c);   // R2 load path
      for (int i = 0; i < 256; i++) begin
        lutF = i[3:0];
        lutG = i[7:4];
        #1;
        check("R3 x=F", x, mF(c, lutF));
        check("R3 y=G", y, mG(c, lutG));
      end
    end
  endtask

  task automatic testMerge();
    for (int s = 0; s < 4; s++) begin
      cfg_t c = '0;
      randTables(c);
      c.xOutH = 1'b1;
      c.yOutH = 1'b1;
      c.selH1 = 2'(s);
      loadCfg(c);
      for (int i = 0; i < 64; i++) begin
        lutF = 4'($urandom);
        lutG = 4'($urandom);
        ctl  = 4'($urandom);
        #1;
        check("R4 R5 x=H", x, mH(c, lutF, lutG, ctl));
        check("R4 y=H", y, mH(c, lutF, lutG, ctl));
      end
    end
  endtask

  task automatic testCapture();
    for (int p = 0; p < 2; p++) begin
      cfg_t c = '0;
      randTables(c);
      c.xDSel  = p ? 2'd2 : 2'd0;
      c.yDSel  = p ? 2'd3 : 2'd1;
      c.selH1  = 2'd0;
      c.selDin = 2'd1;
      loadCfg(c);
      for (int i = 0; i < 24; i++) begin
        logic ex, ey;
        @(negedge clk);
        lutF = 4'($urandom);
        lutG = 4'($urandom);
        ctl  = 4'($urandom);
        ex = mD(c, c.xDSel, lutF, lutG, ctl);
        ey = mD(c, c.yDSel, lutF, lutG, ctl);
        @(negedge clk);
        check("R6 xq", xq, ex);
        check("R6 R5 yq", yq, ey);
      end
    end
  endtask

  task automatic testEnable();
    cfg_t c = '0;
    logic hx, hy;
    randTables(c);
    c.ecUse = 1'b1;
    c.selEc = 2'd2;
    c.xDSel = 2'd3;
    c.yDSel = 2'd3;
    c.selDin = 2'd0;
    loadCfg(c);
    @(negedge clk);
    ctl = 4'b0101;        // enable on, din 1
    @(negedge clk);
    check("R6 en on xq", xq, 1'b1);
    hx = xq;
    hy = yq;
    ctl = 4'b0000;        // enable off, din 0
    repeat (3) @(negedge clk);
    check("R7 hold xq", xq, hx);
    check("R7 hold yq", yq, hy);
    ctl = 4'b0100;
    @(negedge clk);
    check("R7 reenable xq", xq, 1'b0);
  endtask

  task automatic testSetReset();
    cfg_t c = '0;
    randTables(c);
    c.srUse  = 1'b1;
    c.selSr  = 2'd3;
    c.xSrSet = 1'b1;
    c.ySrSet = 1'b0;
    c.xDSel  = 2'd3;
    c.yDSel  = 2'd3;
    c.selDin = 2'd1;
    loadCfg(c);
    @(negedge clk);
    ctl = 4'b0010;        // din 1, no S/R
    @(negedge clk);
    check("R6 pre yq", yq, 1'b1);
    ctl = 4'b0000;
    @(negedge clk);
    check("R6 pre xq", xq, 1'b0);
    #1 ctl = 4'b1000;     // S/R asserted between edges
    #0.5;
    check("R8 async set xq", xq, 1'b1);
    check("R8 async clr yq", yq, 1'b0);
    ctl = 4'b1010;        // din 1 but S/R dominates y
    @(negedge clk);
    @(negedge clk);
    check("R8 dominate yq", yq, 1'b0);
    // S/R unused: line ignored
    c.srUse = 1'b0;
    loadCfg(c);
    ctl = 4'b0000;
    @(negedge clk);
    @(negedge clk);
    ctl = 4'b1000;
    #1;
    check("R8 unused xq", xq, 1'b0);
    @(negedge clk);
    check("R8 unused clocked xq", xq, 1'b0);
  endtask

  task automatic testLoadHold();
    cfg_t c = '0;
    cfg_t n = '0;
    c.xDSel = 2'd3;
    c.yDSel = 2'd3;
    c.selDin = 2'd0;
    loadCfg(c);
    @(negedge clk);
    ctl = 4'b0001;
    @(negedge clk);
    check("R6 pre-load xq", xq, 1'b1);
    n.srUse  = 1'b1;
    n.selSr  = 2'd0;
    n.xSrSet = 1'b0;
    n.ySrSet = 1'b0;
    n.xDSel  = 2'd3;
    n.yDSel  = 2'd3;
    n.selDin = 2'd1;
    ctl = 4'b0001;        // S/R line high, din 0 under new config
    shiftCfg(n);
    check("R9 hold xq", xq, 1'b1);
    check("R9 hold yq", yq, 1'b1);
    cfgEn = 1'b0;
    #1;
    check("R2 R8 after load xq", xq, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testLut4();
    testMerge();
    testCapture();
    testEnable();
    testSetReset();
    testLoadHold();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule